// File: doc/BRIEF.md
# Radio Interrupt Service Sequencer

This block sits between a radio transceiver's interrupt pin and the register-access port that talks to the transceiver over its serial link. When the pin rises, the sequencer reads the 40-bit event status register, decides which of two events took place (a good frame arrived, or a transmission finished), and signals each one to the host as a single-cycle event pulse. After each pulse it writes a fixed clearing pattern back to the status register so that the transceiver drops the serviced flags.

The host can also ask the sequencer to program the transceiver's interrupt enable register. It does this with a one-cycle request that carries two enable bits. Register transactions are never started while the shared link is busy, and they never overlap each other. A pin edge that arrives while a transaction is running, or while another master holds the link, is remembered and serviced afterwards.

The register-access port is a request/done handshake. The sequencer holds `acc_req` and its fields steady until the link answers with a one-cycle `acc_done`. For reads, the data is returned on `acc_rdata` in that same cycle. Every transaction addresses offset zero of the selected register.

Top module: `radio_irq_sequencer`

## Requirements
- R1: After reset, `acc_req`, `rx_evt` and `tx_evt` are low, and no transaction starts until an interrupt edge or an enable-programming request arrives.
- R2: Service starts only on a low-to-high transition of `irq_pin`. A pin that stays high produces exactly one service, and a falling edge produces none.
- R3: Every service pass begins with one read (`acc_wr`=0) of register 0x0F (`acc_reg`) with `acc_len`=5 bytes.
- R4: If status bit 14 is set, `rx_evt` pulses high for exactly one cycle. A write of 2 bytes with data 0x6F00 to register 0x0F starts in that same cycle.
- R5: If status bit 7 is set, `tx_evt` pulses high for exactly one cycle. A write of 1 byte with data 0xF8 to register 0x0F starts in that same cycle.
- R6: When both bits are set, the receive pulse and its clearing write complete before the transmit pulse is issued.
- R7: When neither bit is set, the pass ends after the read, with no write and no event pulse. All other status bits are ignored.
- R8: A one-cycle `mask_go` causes a 2-byte write to register 0x0E. The data has bit 14 equal to `rx_irq_en`, bit 7 equal to `tx_irq_en`, and all other bits zero.
- R9: No transaction starts while `link_busy` is high. Edges that arrive during `link_busy` or during a running pass are held and serviced afterwards. Any number of such edges collapses into one further pass.
- R10: While `acc_req` is high and `acc_done` is low, `acc_wr`, `acc_reg`, `acc_len` and `acc_wdata` do not change, and `acc_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 1 | Transceiver interrupt pin (asynchronous, synchronised inside) |
| link_busy | input | 1 | Another master currently owns the register link |
| mask_go | input | 1 | One-cycle request to program the interrupt enable register |
| rx_irq_en | input | 1 | Receive-good interrupt enable, sampled with `mask_go` |
| tx_irq_en | input | 1 | Transmit-done interrupt enable, sampled with `mask_go` |
| acc_req | output | 1 | Register transaction request, held until `acc_done` |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_reg | output | 6 | Register identifier |
| acc_len | output | 3 | Transfer length in bytes |
| acc_wdata | output | 40 | Write data, least significant byte first on the link |
| acc_rdata | input | 40 | Read data, valid with `acc_done` |
| acc_done | input | 1 | One-cycle completion of the current transaction |
| rx_evt | output | 1 | One-cycle good-frame-received event |
| tx_evt | output | 1 | One-cycle transmit-done event |

## Verification
The assertions assume that the link raises `acc_done` only while `acc_req` is high, and for one cycle per transaction. They also assume that `link_busy` is driven only by other masters and never blocks a transaction that is already running. The bench's link model follows these rules: it waits a chosen latency after seeing a request, raises the done pulse once, and then waits for the request to drop. Pin pulses in the bench are held for several cycles, so the two-stage synchroniser always sees them. `link_busy` is raised only while the sequencer is idle.

// File: rtl/ris_pkg.sv
package ris_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_CHK_RX,
    S_CLR_RX,
    S_CHK_TX,
    S_CLR_TX,
    S_MASK
  } ris_state_e;

endpackage

// File: rtl/ris_edge_capture.sv
module ris_edge_capture #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic consume,
  output logic pend
);
  localparam int SH_W = SYNC + 1;

  logic [SH_W-1:0] sh;
  logic rose;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SH_W-2:0], pin};
  end

  assign rose = sh[SYNC-1] & ~sh[SYNC];

  // a new edge wins over the consume of an older one
  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (rose)    pend <= 1'b1;
    else if (consume) pend <= 1'b0;
  end

  a_r9_edge_latched: assert property (@(posedge clk) disable iff (rst)
    rose |=> pend);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!pend && !rose) |=> !pend);

endmodule

// File: rtl/ris_status_latch.sv
module ris_status_latch #(
  parameter int DW     = 40,
  parameter int RX_BIT = 14,
  parameter int TX_BIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] rdata,
  output logic          rx_hit,
  output logic          tx_hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hit <= 1'b0;
      tx_hit <= 1'b0;
    end else if (load) begin
      rx_hit <= rdata[RX_BIT];
      tx_hit <= rdata[TX_BIT];
    end
  end

  a_r7_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(rx_hit) && $stable(tx_hit));

endmodule

// File: rtl/ris_svc_fsm.sv
module ris_svc_fsm
  import ris_pkg::*;
#(
  parameter int DW           = 40,
  parameter int REG_W        = 6,
  parameter int LEN_W        = 3,
  parameter int STAT_REG     = 15,
  parameter int MASK_REG     = 14,
  parameter int STAT_BYTES   = 5,
  parameter int RX_BIT       = 14,
  parameter int TX_BIT       = 7,
  parameter int RX_CLR       = 'h6F00,
  parameter int RX_CLR_BYTES = 2,
  parameter int TX_CLR       = 'hF8,
  parameter int TX_CLR_BYTES = 1,
  parameter int MASK_BYTES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_pend,
  input  logic             link_busy,
  input  logic             mask_go,
  input  logic             rx_irq_en,
  input  logic             tx_irq_en,
  input  logic             rx_hit,
  input  logic             tx_hit,
  input  logic             acc_done,
  output logic             irq_take,
  output logic             stat_load,
  output logic             acc_req,
  output logic             acc_wr,
  output logic [REG_W-1:0] acc_reg,
  output logic [LEN_W-1:0] acc_len,
  output logic [DW-1:0]    acc_wdata,
  output logic             rx_evt,
  output logic             tx_evt
);
  localparam logic [DW-1:0]    RX_EN_BIT = DW'(1) << RX_BIT;
  localparam logic [DW-1:0]    TX_EN_BIT = DW'(1) << TX_BIT;
  localparam logic [REG_W-1:0] STAT_ID   = REG_W'(STAT_REG);
  localparam logic [REG_W-1:0] MASK_ID   = REG_W'(MASK_REG);

  ris_state_e    st;
  logic          mpend;
  logic [DW-1:0] mval;
  logic [DW-1:0] mval_in;

  assign mval_in   = (rx_irq_en ? RX_EN_BIT : '0) | (tx_irq_en ? TX_EN_BIT : '0);
  assign irq_take  = (st == S_IDLE) && !link_busy && irq_pend;
  assign stat_load = (st == S_READ) && acc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mpend     <= 1'b0;
      mval      <= '0;
      acc_req   <= 1'b0;
      acc_wr    <= 1'b0;
      acc_reg   <= '0;
      acc_len   <= '0;
      acc_wdata <= '0;
      rx_evt    <= 1'b0;
      tx_evt    <= 1'b0;
    end else begin
      rx_evt <= 1'b0;
      tx_evt <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!link_busy) begin
            if (irq_pend) begin
              acc_req   <= 1'b1;
              acc_wr    <= 1'b0;
              acc_reg   <= STAT_ID;
              acc_len   <= LEN_W'(STAT_BYTES);
              acc_wdata <= '0;
              st        <= S_READ;
            end else if (mpend) begin
              acc_req   <= 1'b1;
              acc_wr    <= 1'b1;
              acc_reg   <= MASK_ID;
              acc_len   <= LEN_W'(MASK_BYTES);
              acc_wdata <= mval;
              mpend     <= 1'b0;
              st        <= S_MASK;
            end
          end
        end
        S_READ: begin
          if (acc_done) begin
            acc_req <= 1'b0;
            st      <= S_CHK_RX;
          end
        end
        S_CHK_RX: begin
          if (rx_hit) begin
            rx_evt    <= 1'b1;
            acc_req   <= 1'b1;
            acc_wr    <= 1'b1;
            acc_reg   <= STAT_ID;
            acc_len   <= LEN_W'(RX_CLR_BYTES);
            acc_wdata <= DW'(RX_CLR);
            st        <= S_CLR_RX;
          end else begin
            st <= S_CHK_TX;
          end
        end
        S_CLR_RX: begin
          if (acc_done) begin
            acc_req <= 1'b0;
            st      <= S_CHK_TX;
          end
        end
        S_CHK_TX: begin
          if (tx_hit) begin
            tx_evt    <= 1'b1;
            acc_req   <= 1'b1;
            acc_wr    <= 1'b1;
            acc_reg   <= STAT_ID;
            acc_len   <= LEN_W'(TX_CLR_BYTES);
            acc_wdata <= DW'(TX_CLR);
            st        <= S_CLR_TX;
          end else begin
            st <= S_IDLE;
          end
        end
        S_CLR_TX, S_MASK: begin
          if (acc_done) begin
            acc_req <= 1'b0;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
      // a fresh request overrides the clear done when a write is launched
      if (mask_go) begin
        mpend <= 1'b1;
        mval  <= mval_in;
      end
    end
  end

  a_r10_hold_fields: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_done) |=> acc_req && $stable(acc_wr) && $stable(acc_reg)
                               && $stable(acc_len) && $stable(acc_wdata));

  a_r3_read_shape: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_wr) |-> acc_reg == STAT_ID && acc_len == LEN_W'(STAT_BYTES));

  a_r4_rx_clear: assert property (@(posedge clk) disable iff (rst)
    rx_evt |-> acc_req && acc_wr && acc_reg == STAT_ID
               && acc_len == LEN_W'(RX_CLR_BYTES) && acc_wdata == DW'(RX_CLR));

  a_r5_tx_clear: assert property (@(posedge clk) disable iff (rst)
    tx_evt |-> acc_req && acc_wr && acc_reg == STAT_ID
               && acc_len == LEN_W'(TX_CLR_BYTES) && acc_wdata == DW'(TX_CLR));

  a_r4_rx_single: assert property (@(posedge clk) disable iff (rst)
    rx_evt |=> !rx_evt);

  a_r5_tx_single: assert property (@(posedge clk) disable iff (rst)
    tx_evt |=> !tx_evt);

  a_r8_mask_shape: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_reg == MASK_ID) |-> acc_wr && acc_len == LEN_W'(MASK_BYTES)
      && (acc_wdata & ~(RX_EN_BIT | TX_EN_BIT)) == '0);

  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    ($rose(acc_req) && $past(st == S_IDLE)) |-> $past(!link_busy));

endmodule

// File: rtl/radio_irq_sequencer.sv
module radio_irq_sequencer #(
  parameter int DW           = 40,
  parameter int REG_W        = 6,
  parameter int LEN_W        = 3,
  parameter int SYNC         = 2,
  parameter int STAT_REG     = 15,
  parameter int MASK_REG     = 14,
  parameter int STAT_BYTES   = 5,
  parameter int RX_BIT       = 14,
  parameter int TX_BIT       = 7,
  parameter int RX_CLR       = 'h6F00,
  parameter int RX_CLR_BYTES = 2,
  parameter int TX_CLR       = 'hF8,
  parameter int TX_CLR_BYTES = 1,
  parameter int MASK_BYTES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_pin,
  input  logic             link_busy,
  input  logic             mask_go,
  input  logic             rx_irq_en,
  input  logic             tx_irq_en,
  output logic             acc_req,
  output logic             acc_wr,
  output logic [REG_W-1:0] acc_reg,
  output logic [LEN_W-1:0] acc_len,
  output logic [DW-1:0]    acc_wdata,
  input  logic [DW-1:0]    acc_rdata,
  input  logic             acc_done,
  output logic             rx_evt,
  output logic             tx_evt
);
  logic irq_pend, irq_take, stat_load, rx_hit, tx_hit;

  ris_edge_capture #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst(rst), .pin(irq_pin), .consume(irq_take), .pend(irq_pend)
  );

  ris_status_latch #(.DW(DW), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_stat (
    .clk(clk), .rst(rst), .load(stat_load), .rdata(acc_rdata),
    .rx_hit(rx_hit), .tx_hit(tx_hit)
  );

  ris_svc_fsm #(
    .DW(DW), .REG_W(REG_W), .LEN_W(LEN_W), .STAT_REG(STAT_REG),
    .MASK_REG(MASK_REG), .STAT_BYTES(STAT_BYTES), .RX_BIT(RX_BIT),
    .TX_BIT(TX_BIT), .RX_CLR(RX_CLR), .RX_CLR_BYTES(RX_CLR_BYTES),
    .TX_CLR(TX_CLR), .TX_CLR_BYTES(TX_CLR_BYTES), .MASK_BYTES(MASK_BYTES)
  ) u_fsm (
    .clk(clk), .rst(rst), .irq_pend(irq_pend), .link_busy(link_busy),
    .mask_go(mask_go), .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
    .rx_hit(rx_hit), .tx_hit(tx_hit), .acc_done(acc_done),
    .irq_take(irq_take), .stat_load(stat_load),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_reg(acc_reg), .acc_len(acc_len),
    .acc_wdata(acc_wdata), .rx_evt(rx_evt), .tx_evt(tx_evt)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !acc_req && !rx_evt && !tx_evt);

endmodule

// File: tb/radio_irq_sequencer_tb.sv
`timescale 1ns/1ps
module radio_irq_sequencer_tb;
  localparam int ST = 15, MK = 14;

  logic clk = 1'b0, rst = 1'b1;
  logic irq_pin = 0, link_busy = 0, mask_go = 0, rx_irq_en = 0, tx_irq_en = 0;
  logic acc_req, acc_wr, acc_done = 0, rx_evt, tx_evt;
  logic [5:0] acc_reg;
  logic [2:0] acc_len;
  logic [39:0] acc_wdata, acc_rdata = '0;

  always #2.5 clk = ~clk;

  radio_irq_sequencer u_dut (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .link_busy(link_busy),
    .mask_go(mask_go), .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_reg(acc_reg), .acc_len(acc_len),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_done(acc_done),
    .rx_evt(rx_evt), .tx_evt(tx_evt)
  );

  int n_chk = 0, n_fail = 0;
  int lat = 3;
  logic [39:0] stat_val = '0;
  logic [51:0] lg [256];
  int lg_n = 0, base = 0;
  logic [51:0] ex [16];
  int ex_n = 0;
  logic seen = 0;
  logic [49:0] hold;
  int stab_err = 0, rx_long = 0, tx_long = 0;
  logic prev_rx = 0, prev_tx = 0;
  int cnt = 0;
  bit finished = 0;

  function automatic logic [51:0] mk(input logic [1:0] t, input logic w,
      input logic [5:0] r, input logic [2:0] l, input logic [39:0] d);
    return {t, w, r, l, d};
  endfunction

  task automatic push(input logic [51:0] v);
    if (lg_n < 256) lg[lg_n] = v;
    lg_n++;
  endtask

  // observer: events and transaction starts, in order
  always @(negedge clk) begin
    if (rst) begin
      seen = 0; prev_rx = 0; prev_tx = 0;
    end else begin
      if (rx_evt && prev_rx) rx_long++;
      if (tx_evt && prev_tx) tx_long++;
      prev_rx = rx_evt; prev_tx = tx_evt;
      if (rx_evt) push(mk(2'd1, 0, 0, 0, 0));
      if (tx_evt) push(mk(2'd2, 0, 0, 0, 0));
      if (acc_req && !seen)
        push(mk(2'd0, acc_wr, acc_reg, acc_len, acc_wr ? acc_wdata : 40'd0));
      else if (acc_req && seen && hold != {acc_wr, acc_reg, acc_len, acc_wdata})
        stab_err++;
      seen = acc_req;
      hold = {acc_wr, acc_reg, acc_len, acc_wdata};
    end
  end

  // link model
  always @(negedge clk) begin
    if (rst) begin
      acc_done = 0; cnt = 0;
    end else if (acc_done) begin
      acc_done = 0;
    end else if (acc_req) begin
      if (cnt >= lat) begin
        acc_done = 1; acc_rdata = stat_val; cnt = 0;
      end else cnt++;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cmp_log(input string rq);
    check(lg_n - base == ex_n, rq, 64'(lg_n - base), 64'(ex_n));
    for (int i = 0; i < ex_n; i++)
      if (base + i < lg_n)
        check(lg[base+i] == ex[i], rq, 64'(lg[base+i]), 64'(ex[i]));
    base = lg_n; ex_n = 0;
  endtask

  task automatic add_service(input logic [39:0] s);
    ex[ex_n++] = mk(0, 0, ST, 5, 0);
    if (s[14]) begin
      ex[ex_n++] = mk(1, 0, 0, 0, 0);
      ex[ex_n++] = mk(0, 1, ST, 2, 40'h6F00);
    end
    if (s[7]) begin
      ex[ex_n++] = mk(2, 0, 0, 0, 0);
      ex[ex_n++] = mk(0, 1, ST, 1, 40'hF8);
    end
  endtask

  task automatic pulse_pin();
    irq_pin = 1; repeat (6) @(negedge clk);
    irq_pin = 0; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!acc_req && !rx_evt && !tx_evt, "R1 in reset", {acc_req, rx_evt, tx_evt}, 0);
    rst = 0;
    repeat (20) @(negedge clk);
    check(!acc_req && lg_n == 0, "R1 idle after reset", 64'(lg_n), 0);

    // R3 R4 R5 R6 R7: sweep of both event bits under two background patterns
    for (int pat = 0; pat < 2; pat++)
      for (int b = 0; b < 4; b++) begin
        logic [39:0] s;
        s = (pat == 0) ? 40'd0 : (40'hA5_C3F0_BF7F & ~40'h4080);
        s[14] = b[0]; s[7] = b[1];
        stat_val = s;
        add_service(s);
        pulse_pin();
        repeat (40) @(negedge clk);
        cmp_log("R3/R4/R5/R6/R7 service");
      end

    // R2: held-high pin gives one pass, fall gives none
    stat_val = 40'h4080;
    irq_pin = 1;
    add_service(stat_val);
    repeat (80) @(negedge clk);
    cmp_log("R2 held high");
    irq_pin = 0;
    repeat (40) @(negedge clk);
    cmp_log("R2 falling edge");

    // R8: mask programming sweep
    for (int m = 0; m < 4; m++) begin
      rx_irq_en = m[0]; tx_irq_en = m[1]; mask_go = 1;
      @(negedge clk); mask_go = 0;
      ex[ex_n++] = mk(0, 1, MK, 2, (m[0] ? 40'h4000 : 40'd0) | (m[1] ? 40'h80 : 40'd0));
      repeat (20) @(negedge clk);
      cmp_log("R8 mask write");
    end

    // R9: edges under link_busy are held; two collapse into one
    stat_val = 40'h80;
    link_busy = 1;
    pulse_pin(); pulse_pin();
    repeat (20) @(negedge clk);
    check(!acc_req, "R9 no request while busy", {63'd0, acc_req}, 0);
    cmp_log("R9 nothing while busy");
    link_busy = 0;
    add_service(stat_val);
    repeat (40) @(negedge clk);
    cmp_log("R9 serviced after busy");

    // R9: edge during own read is serviced after the pass
    lat = 8;
    stat_val = 40'h4000;
    irq_pin = 1;
    while (!acc_req) @(negedge clk);
    irq_pin = 0; repeat (3) @(negedge clk);
    irq_pin = 1; repeat (3) @(negedge clk);
    irq_pin = 0;
    add_service(stat_val); add_service(stat_val);
    repeat (80) @(negedge clk);
    cmp_log("R9 edge during pass");
    lat = 3;

    // R10 and pulse widths
    check(stab_err == 0, "R10 fields held", 64'(stab_err), 0);
    check(rx_long == 0, "R4 single-cycle rx_evt", 64'(rx_long), 0);
    check(tx_long == 0, "R5 single-cycle tx_evt", 64'(tx_long), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule